// File: doc/BRIEF.md
# Hash Chaining-State Save/Restore Port

This block sits between a register bus and a multi-algorithm hash engine. It lets software pull the engine's chaining state out word by word and push it back in, all through one auto-indexing chain address. A context switch saves the state into memory and later restores it. After the last block of a message, the same words read out form the digest. The number of words in a full walk follows the algorithm chosen in the mode register. The two 256-bit-state algorithm families move 8 words, and the two 512-bit-state algorithms move 16 words.

The processed message length is kept in two 32-bit halves. A one-bit `len_nonzero` output tells the engine that a restore has taken place: a length of zero means the next job is a fresh start. A status register reports the engine's busy input. While busy is high, chain reads return the current word without stepping the pointer, and writes to the chain and length registers are dropped. The compression function is not part of the block. It is modelled as a word array that the engine can overwrite through its own update port, plus the busy input.

A three-state walk machine tracks the pointer. The states are IDLE (pointer at word 0, no walk open), SAVE (a read walk is open) and RESTORE (a write walk is open). The transitions are: start-save from IDLE on a chain read, start-restore from IDLE on a chain write, step within the same direction, wrap back to IDLE when the pointer reaches the word count, reverse-restart when an access of the other direction arrives during an open walk (that access uses word 0), and mode-reset to IDLE on any mode write.

Top module: `hash_state_port`

## Requirements
- R1: After reset the mode code is 0, both length halves are 0, every state word is 0, `rd_valid` is low and the walk pointer is at word 0.
- R2: A read request gives `rd_valid` high with its data on the cycle after the request. A write request gives no `rd_valid`.
- R3: With busy low, successive reads of the chain register (address 1) return state words 0, 1, 2, … in order. After the last word of the current count, the next read returns word 0 again.
- R4: With busy low, successive writes to the chain register load state words 0, 1, 2, … in order, wrapping at the word count.
- R5: The mode register (address 0) holds a 3-bit algorithm code in bits [2:0]. Codes 3 (SHA-384) and 4 (SHA-512) give a 16-word walk. Codes 0 (SHA-256), 1 (SHA-224), 2 (SM3) and the unused codes 5–7 give an 8-word walk.
- R6: Any mode-register write returns the pointer to word 0 and closes the walk. After a 7-word SHA-224 digest read, a mode write makes the next chain read return word 0.
- R7: Length-low (address 2) and length-high (address 3) read back what was written. `len_nonzero` is high exactly when either half is nonzero.
- R8: Bit 0 of the status register (address 4) reads as the busy input, and bits [31:1] read as 0.
- R9: While busy is high, a chain read returns the word at the pointer and leaves the pointer where it was.
- R10: While busy is high, writes to the chain and length registers change nothing.
- R11: An access of the opposite direction during an open walk restarts the walk at word 0, and that access uses word 0.
- R12: When `eng_we` is high, state word `eng_idx` takes `eng_wdata`. This shows on `eng_state` (word i at bits [32i+31:32i]) and in later chain reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (0 mode, 1 chain, 2 length low, 3 length high, 4 status) |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| eng_busy | input | 1 | Engine is computing |
| eng_we | input | 1 | Engine updates one state word |
| eng_idx | input | 4 | Index of the word the engine updates |
| eng_wdata | input | 32 | Word value from the engine |
| eng_state | output | 512 | All state words, flattened, for the engine |
| len_nonzero | output | 1 | Saved length is nonzero, so a restore has occurred |

## Verification
The walk is exercised with an 8-word save after an 8-word restore, a full 16-word restore and save, an unused mode code, and a 7-word SHA-224 digest read closed by a mode write. Together these separate a count that follows the algorithm code from a fixed count, and show that the wrap lands on word 0. Reads and writes made while busy is held high are followed by an idle read. That read shows whether the pointer moved or whether a word or length half was overwritten. A write arriving in the middle of a save walk, and an engine-side word update, show that the reverse restart targets word 0 and that both writers reach the same storage.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    localparam int ADDR_W = 3;
    localparam int ALGO_W = 3;

    localparam logic [ADDR_W-1:0] REG_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CHAIN  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_LEN_LO = 3'd2;
    localparam logic [ADDR_W-1:0] REG_LEN_HI = 3'd3;
    localparam logic [ADDR_W-1:0] REG_STATUS = 3'd4;

    localparam logic [ALGO_W-1:0] ALG_SHA256 = 3'd0;
    localparam logic [ALGO_W-1:0] ALG_SHA224 = 3'd1;
    localparam logic [ALGO_W-1:0] ALG_SM3    = 3'd2;
    localparam logic [ALGO_W-1:0] ALG_SHA384 = 3'd3;
    localparam logic [ALGO_W-1:0] ALG_SHA512 = 3'd4;

    typedef enum logic [1:0] {
        WALK_IDLE    = 2'd0,
        WALK_SAVE    = 2'd1,
        WALK_RESTORE = 2'd2
    } walk_state_t;
endpackage

// File: rtl/hsp_walk_fsm.sv
module hsp_walk_fsm
    import hsp_pkg::*;
#(
    parameter int MAX_WORDS   = 16,
    parameter int SHORT_WORDS = 8,
    localparam int IDX_W = $clog2(MAX_WORDS),
    localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [ALGO_W-1:0] mode_code,
    input  logic              chain_acc,
    input  logic              chain_wr,
    input  logic              busy,
    output logic [IDX_W-1:0]  acc_idx,
    output logic              word_we,
    output logic [IDX_W-1:0]  ptr,
    output logic [CNT_W-1:0]  word_cnt,
    output logic [ALGO_W-1:0] algo,
    output walk_state_t       state
);
    walk_state_t       state_n;
    logic [IDX_W-1:0]  ptr_n;
    logic [ALGO_W-1:0] algo_n;
    logic [IDX_W-1:0]  base;
    logic [CNT_W-1:0]  step;
    walk_state_t       dir;
    logic              move;

    function automatic logic [CNT_W-1:0] words_for(input logic [ALGO_W-1:0] code);
        if (code == ALG_SHA384 || code == ALG_SHA512)
            return CNT_W'(MAX_WORDS);
        else
            return CNT_W'(SHORT_WORDS);
    endfunction

    assign word_cnt = words_for(algo);
    assign move     = chain_acc && !busy;
    assign dir      = chain_wr ? WALK_RESTORE : WALK_SAVE;

    // Word the current access lands on: a reversal restarts at word 0.
    always_comb begin
        case (state)
            WALK_IDLE:    base = ptr;
            WALK_SAVE:    base = chain_wr ? '0 : ptr;
            WALK_RESTORE: base = chain_wr ? ptr : '0;
            default:      base = '0;
        endcase
        step = CNT_W'(base) + CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WALK_IDLE;
            ptr   <= '0;
            algo  <= ALG_SHA256;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
            algo  <= algo_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        algo_n  = algo;
        if (mode_wr) begin
            algo_n  = mode_code;
            state_n = WALK_IDLE;
            ptr_n   = '0;
        end else if (move) begin
            unique case (state)
                WALK_IDLE, WALK_SAVE, WALK_RESTORE: begin
                    if (step >= word_cnt) begin
                        state_n = WALK_IDLE;
                        ptr_n   = '0;
                    end else begin
                        state_n = dir;
                        ptr_n   = step[IDX_W-1:0];
                    end
                end
                default: begin
                    state_n = WALK_IDLE;
                    ptr_n   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        acc_idx = move ? base : ptr;
        word_we = move && chain_wr;
    end
endmodule

// File: rtl/hsp_state_bank.sv
module hsp_state_bank #(
    parameter int DATA_W    = 32,
    parameter int MAX_WORDS = 16,
    localparam int IDX_W = $clog2(MAX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [IDX_W-1:0]            bus_idx,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        eng_we,
    input  logic [IDX_W-1:0]            eng_idx,
    input  logic [DATA_W-1:0]           eng_wdata,
    output logic [DATA_W-1:0]           rd_word,
    output logic [MAX_WORDS*DATA_W-1:0] flat
);
    for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (eng_we && eng_idx == IDX_W'(i))
                q <= eng_wdata;
            else if (bus_we && bus_idx == IDX_W'(i))
                q <= bus_wdata;
        end
        assign flat[i*DATA_W +: DATA_W] = q;
    end

    assign rd_word = flat[bus_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/hsp_len_regs.sv
module hsp_len_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              busy,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] len_lo,
    output logic [DATA_W-1:0] len_hi,
    output logic              nonzero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_lo <= '0;
            len_hi <= '0;
        end else if (!busy) begin
            if (wr_lo) len_lo <= wdata;
            if (wr_hi) len_hi <= wdata;
        end
    end

    assign nonzero = (len_lo != '0) || (len_hi != '0);
endmodule

// File: rtl/hash_state_port.sv
module hash_state_port
    import hsp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int MAX_WORDS   = 16,
    parameter int SHORT_WORDS = 8,
    localparam int IDX_W = $clog2(MAX_WORDS),
    localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    input  logic                        eng_busy,
    input  logic                        eng_we,
    input  logic [IDX_W-1:0]            eng_idx,
    input  logic [DATA_W-1:0]           eng_wdata,
    output logic [MAX_WORDS*DATA_W-1:0] eng_state,
    output logic                        len_nonzero
);
    logic              mode_wr, chain_acc, len_lo_wr, len_hi_wr, rd_req;
    logic [IDX_W-1:0]  acc_idx, walk_ptr;
    logic              word_we;
    logic [CNT_W-1:0]  word_cnt;
    logic [ALGO_W-1:0] algo;
    walk_state_t       walk_st;
    logic [DATA_W-1:0] chain_word, len_lo_q, len_hi_q, rd_mux;

    assign mode_wr   = bus_valid && bus_write && bus_addr == REG_MODE;
    assign chain_acc = bus_valid && bus_addr == REG_CHAIN;
    assign len_lo_wr = bus_valid && bus_write && bus_addr == REG_LEN_LO;
    assign len_hi_wr = bus_valid && bus_write && bus_addr == REG_LEN_HI;
    assign rd_req    = bus_valid && !bus_write;

    hsp_walk_fsm #(.MAX_WORDS(MAX_WORDS), .SHORT_WORDS(SHORT_WORDS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_code (bus_wdata[ALGO_W-1:0]),
        .chain_acc (chain_acc),
        .chain_wr  (bus_write),
        .busy      (eng_busy),
        .acc_idx   (acc_idx),
        .word_we   (word_we),
        .ptr       (walk_ptr),
        .word_cnt  (word_cnt),
        .algo      (algo),
        .state     (walk_st)
    );

    hsp_state_bank #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (word_we),
        .bus_idx   (acc_idx),
        .bus_wdata (bus_wdata),
        .eng_we    (eng_we),
        .eng_idx   (eng_idx),
        .eng_wdata (eng_wdata),
        .rd_word   (chain_word),
        .flat      (eng_state)
    );

    hsp_len_regs #(.DATA_W(DATA_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (len_lo_wr),
        .wr_hi   (len_hi_wr),
        .busy    (eng_busy),
        .wdata   (bus_wdata),
        .len_lo  (len_lo_q),
        .len_hi  (len_hi_q),
        .nonzero (len_nonzero)
    );

    always_comb begin
        case (bus_addr)
            REG_MODE:   rd_mux = DATA_W'(algo);
            REG_CHAIN:  rd_mux = chain_word;
            REG_LEN_LO: rd_mux = len_lo_q;
            REG_LEN_HI: rd_mux = len_hi_q;
            REG_STATUS: rd_mux = DATA_W'(eng_busy);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/hsp_checker.sv
module hsp_checker
    import hsp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              eng_busy,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [IDX_W-1:0]  ptr,
    input logic [CNT_W-1:0]  word_cnt,
    input walk_state_t       walk_state,
    input logic [DATA_W-1:0] len_lo
);
    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);
    assert_no_write_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid);
    assert_save_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == REG_CHAIN && !eng_busy &&
         walk_state != WALK_RESTORE && (CNT_W'(ptr) + CNT_W'(1)) < word_cnt)
        |=> ptr == $past(ptr) + IDX_W'(1));
    assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(ptr) < word_cnt);
    assert_mode_clears_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == REG_MODE) |=> (ptr == '0 && walk_state == WALK_IDLE));
    assert_idle_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_state == WALK_IDLE |-> ptr == '0);
    assert_status_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == REG_STATUS) |=> rd_data[0] == $past(eng_busy));
    assert_busy_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == REG_CHAIN && eng_busy) |=> $stable(ptr));
    assert_busy_len_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == REG_LEN_LO && eng_busy) |=> $stable(len_lo));
endmodule

bind hash_state_port hsp_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
) u_hsp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .eng_busy   (eng_busy),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ptr        (walk_ptr),
    .word_cnt   (word_cnt),
    .walk_state (walk_st),
    .len_lo     (len_lo_q)
);

// File: tb/hash_state_port_bench.sv
module hash_state_port_bench;
    localparam int DW = 32;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          eng_busy = 1'b0, eng_we = 1'b0;
    logic [3:0]    eng_idx = '0;
    logic [DW-1:0] eng_wdata = '0;
    logic [NW*DW-1:0] eng_state;
    logic          len_nonzero;

    int n_checks = 0, n_fail = 0;
    logic [DW-1:0] last_rd;
    logic          last_v;
    logic [DW-1:0] exp_w [NW];

    always #10 clk = ~clk;

    hash_state_port u_hash_state_port (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .eng_busy(eng_busy), .eng_we(eng_we), .eng_idx(eng_idx),
        .eng_wdata(eng_wdata), .eng_state(eng_state), .len_nonzero(len_nonzero)
    );

    // vector: {is_write, addr[2:0], data[31:0]} ; data is write value or expected read
    function automatic logic [35:0] mk(input logic w, input logic [2:0] a, input logic [31:0] d);
        return {w, a, d};
    endfunction

    localparam logic [35:0] VEC [22] = '{
        mk(1, 3'd0, 32'd0),
        mk(1, 3'd1, 32'hA000_0000), mk(1, 3'd1, 32'hA000_0001),
        mk(1, 3'd1, 32'hA000_0002), mk(1, 3'd1, 32'hA000_0003),
        mk(1, 3'd1, 32'hA000_0004), mk(1, 3'd1, 32'hA000_0005),
        mk(1, 3'd1, 32'hA000_0006), mk(1, 3'd1, 32'hA000_0007),
        mk(0, 3'd1, 32'hA000_0000), mk(0, 3'd1, 32'hA000_0001),
        mk(0, 3'd1, 32'hA000_0002), mk(0, 3'd1, 32'hA000_0003),
        mk(0, 3'd1, 32'hA000_0004), mk(0, 3'd1, 32'hA000_0005),
        mk(0, 3'd1, 32'hA000_0006), mk(0, 3'd1, 32'hA000_0007),
        mk(0, 3'd1, 32'hA000_0000),
        mk(1, 3'd2, 32'h0000_1000), mk(0, 3'd2, 32'h0000_1000),
        mk(1, 3'd3, 32'h0000_0002), mk(0, 3'd3, 32'h0000_0002)
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        last_rd = rd_data;
        last_v  = rd_valid;
    endtask

    task automatic rd_chain(input string req, input logic [DW-1:0] exp);
        acc(1'b0, 3'd1, '0);
        check(req, last_rd, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 len_nonzero", {31'd0, len_nonzero}, 32'd0);
        acc(1'b0, 3'd0, '0); check("R1 mode", last_rd, 32'd0);
        acc(1'b0, 3'd2, '0); check("R1 len_lo", last_rd, 32'd0);
        rd_chain("R1 chain word0", 32'd0);
        acc(1'b0, 3'd0, '0); // harmless; mode-independent

        // R3 R4 R7: table walk
        for (int i = 0; i < 22; i++) begin
            acc(VEC[i][35], VEC[i][34:32], VEC[i][31:0]);
            if (!VEC[i][35]) check("R3/R4/R7 table", last_rd, VEC[i][31:0]);
        end
        for (int i = 0; i < 8; i++) exp_w[i] = 32'hA000_0000 + i;

        // R2: write gives no response
        acc(1'b1, 3'd2, 32'h0000_1000);
        check("R2 no rd_valid on write", {31'd0, last_v}, 32'd0);

        // R5: 16-word walk for SHA-512
        acc(1'b1, 3'd0, 32'd4);
        for (int i = 0; i < 16; i++) begin
            acc(1'b1, 3'd1, 32'h5000_0000 + i);
            exp_w[i] = 32'h5000_0000 + i;
        end
        for (int i = 0; i < 16; i++) rd_chain("R5 sha512 word", exp_w[i]);
        rd_chain("R5 sha512 wrap", exp_w[0]);

        // R5: unused code 5 walks 8 words
        acc(1'b1, 3'd0, 32'd5);
        for (int i = 0; i < 8; i++) acc(1'b0, 3'd1, '0);
        rd_chain("R5 code5 wrap at 8", exp_w[0]);

        // R6: SHA-224 digest of 7 words, then mode write restarts
        acc(1'b1, 3'd0, 32'd1);
        for (int i = 0; i < 7; i++) rd_chain("R6 sha224 digest", exp_w[i]);
        acc(1'b1, 3'd0, 32'd1);
        rd_chain("R6 mode write resets ptr", exp_w[0]);

        // R9: busy read holds pointer
        acc(1'b1, 3'd0, 32'd0);
        rd_chain("R9 pre", exp_w[0]);
        eng_busy = 1'b1;
        rd_chain("R9 busy read", exp_w[1]);
        rd_chain("R9 busy read again", exp_w[1]);
        eng_busy = 1'b0;
        rd_chain("R9 resume", exp_w[1]);
        rd_chain("R9 step", exp_w[2]);

        // R10: busy writes ignored (pointer now at word 3)
        eng_busy = 1'b1;
        acc(1'b1, 3'd1, 32'hDEAD_BEEF);
        acc(1'b1, 3'd2, 32'h0000_1234);
        eng_busy = 1'b0;
        acc(1'b0, 3'd2, '0); check("R10 len_lo kept", last_rd, 32'h0000_1000);
        rd_chain("R10 chain word kept", exp_w[3]);

        // R8: status
        eng_busy = 1'b1;
        acc(1'b0, 3'd4, '0); check("R8 status busy", last_rd, 32'd1);
        eng_busy = 1'b0;
        acc(1'b0, 3'd4, '0); check("R8 status idle", last_rd, 32'd0);

        // R11: reversal restarts at word 0
        acc(1'b1, 3'd0, 32'd0);
        rd_chain("R11 save0", exp_w[0]);
        rd_chain("R11 save1", exp_w[1]);
        acc(1'b1, 3'd1, 32'h7777_0000);
        exp_w[0] = 32'h7777_0000;
        acc(1'b1, 3'd0, 32'd0);
        rd_chain("R11 reversal hit word0", exp_w[0]);
        rd_chain("R11 word1 untouched", exp_w[1]);

        // R12: engine update port
        @(negedge clk);
        eng_we = 1'b1; eng_idx = 4'd5; eng_wdata = 32'hC0DE_0005;
        @(negedge clk);
        eng_we = 1'b0;
        exp_w[5] = 32'hC0DE_0005;
        check("R12 eng_state slice", eng_state[5*DW +: DW], 32'hC0DE_0005);
        acc(1'b1, 3'd0, 32'd0);
        for (int i = 0; i < 5; i++) acc(1'b0, 3'd1, '0);
        rd_chain("R12 chain readback", exp_w[5]);

        // R7: len_nonzero
        check("R7 nonzero", {31'd0, len_nonzero}, 32'd1);
        acc(1'b1, 3'd2, 32'd0);
        check("R7 hi keeps nonzero", {31'd0, len_nonzero}, 32'd1);
        acc(1'b1, 3'd3, 32'd0);
        check("R7 zero length", {31'd0, len_nonzero}, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule